// File: doc/BRIEF.md
# Shared FIFO Partition Controller

This block divides one shared buffer RAM into receive and transmit regions for a set of serial channels. The default set is four UART-type channels and two SPI-type channels. Software writes a staged receive size and a staged transmit size for each channel. A commit write then makes the staged sizes active.

The controller takes a commit only while the affected direction of that class is fully paused, meaning a pause is requested and no channel of that direction has a transfer in flight. Any size write requests a pause of both directions of its class. The pause stays in place until software clears it through the class control register.

Each class owns a fixed window of the RAM.

- Receive regions are packed upward from the bottom of the window, in channel order.
- Transmit regions are packed against the top of the window, also in channel order.

Because of this packing, changing one direction never moves the regions of the other direction. The per-channel FIFO logic gets a base offset, a size and a hold (pause) signal for each region. Software reads the global paused and empty status of each class.

Top module: `fifo_partition_ctrl`

## Requirements
- R1: After reset, every staged and active size is 0 and both pause requests of both classes are set. The status read of each class is 0x606 when no channel is busy. Receive bases equal the class origin, and transmit bases equal the origin plus the window size (UART window 0..511, SPI window 512..767).
- R2: A write to size register 2+ch of a class stages the receive size from data bits [7:0] and the transmit size from bits [23:16]. The staged value reads back at the same offset. The write sets both pause requests of that class, and the active sizes do not change.
- R3: A write to offset 0 of a class loads the receive pause request from data bit 1 and the transmit pause request from bit 9. The hold outputs show the new values after the write's clock edge.
- R4: Status bit 1 (bit 9) is 1 exactly when the receive (transmit) pause request is set and no channel of the class is busy in that direction.
- R5: Status bit 2 (bit 10) is the AND of the receive (transmit) empty flags of the channels whose active size is non-zero. It is 1 when no channel is enabled, because a size of 0 disables a channel's region.
- R6: A write to offset 1 commits the staged receive sizes when data bit 0 is set, and the staged transmit sizes when bit 1 is set. Each commit is taken only if that direction's paused status is 1 in the cycle of the write; otherwise the commit is ignored.
- R7: A commit is dropped in full if the class's active receive plus transmit total after the commit would exceed the class window (512 words for UART, 256 for SPI). A total exactly equal to the window is accepted.
- R8: The receive base of channel k is the origin plus the sum of the active receive sizes of channels below k. The transmit base of channel k is the window end minus the sum of the active transmit sizes of channels k and above.
- R9: Writes addressed to one class (address bit 3: 0 UART, 1 SPI) leave the other class's sizes, pauses and bases unchanged.
- R10: A commit does not clear any pause request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: bit 3 class, bits 2:0 offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address, same map |
| rd_data | output | 32 | Read data (status, 0, or staged sizes) |
| uart_rx_busy | input | NU | Receive transfer in flight, per UART channel |
| uart_tx_busy | input | NU | Transmit transfer in flight, per UART channel |
| uart_rx_empty | input | NU | Receive FIFO empty, per UART channel |
| uart_tx_empty | input | NU | Transmit FIFO empty, per UART channel |
| spi_rx_busy | input | NS | Receive transfer in flight, per SPI channel |
| spi_tx_busy | input | NS | Transmit transfer in flight, per SPI channel |
| spi_rx_empty | input | NS | Receive FIFO empty, per SPI channel |
| spi_tx_empty | input | NS | Transmit FIFO empty, per SPI channel |
| uart_rx_hold | output | 1 | UART receive pause request |
| uart_tx_hold | output | 1 | UART transmit pause request |
| spi_rx_hold | output | 1 | SPI receive pause request |
| spi_tx_hold | output | 1 | SPI transmit pause request |
| uart_rx_size | output | NU*SW | Active UART receive sizes |
| uart_tx_size | output | NU*SW | Active UART transmit sizes |
| uart_rx_base | output | NU*AW | UART receive region bases |
| uart_tx_base | output | NU*AW | UART transmit region bases |
| spi_rx_size | output | NS*SW | Active SPI receive sizes |
| spi_tx_size | output | NS*SW | Active SPI transmit sizes |
| spi_rx_base | output | NS*AW | SPI receive region bases |
| spi_tx_base | output | NS*AW | SPI transmit region bases |

## Verification
The assertions check four properties on every cycle:

- Active sizes change only in the cycle after a commit taken while the direction was paused.
- A pause request falls only after a control write.
- Any size write leaves both pause requests set.
- The active total never exceeds the window, and the receive and transmit regions never overlap.

Only the bench scenarios can show that the computed base offsets and the empty status match the arithmetic for each size pattern. The same holds for a commit landing exactly on the window limit, and for the two classes staying apart.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    // register offsets inside one class (address bits 2:0)
    localparam int unsigned OFF_CTL   = 0;
    localparam int unsigned OFF_UPD   = 1;
    localparam int unsigned OFF_SIZE0 = 2;
    // control / status bit positions
    localparam int unsigned ST_RX_PAUSED = 1;
    localparam int unsigned ST_RX_EMPTY  = 2;
    localparam int unsigned ST_TX_PAUSED = 9;
    localparam int unsigned ST_TX_EMPTY  = 10;
    // commit register bits
    localparam int unsigned UPD_RX_BIT = 0;
    localparam int unsigned UPD_TX_BIT = 1;
    // size register field positions
    localparam int unsigned SZ_RX_LSB = 0;
    localparam int unsigned SZ_TX_LSB = 16;
endpackage

// File: rtl/fpc_layout.sv
module fpc_layout #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned ORIGIN = 0,
    parameter int unsigned WORDS  = 512
) (
    input  logic [NCH-1:0][SIZE_W-1:0] rx_size,
    input  logic [NCH-1:0][SIZE_W-1:0] tx_size,
    output logic [NCH-1:0][ADDR_W-1:0] rx_base,
    output logic [NCH-1:0][ADDR_W-1:0] tx_base
);
    localparam int unsigned WIN_END = ORIGIN + WORDS;

    logic [ADDR_W-1:0] rx_acc;
    logic [ADDR_W-1:0] tx_acc;

    // receive regions grow upward from the window origin
    always_comb begin
        rx_acc = '0;
        for (int k = 0; k < NCH; k++) begin
            rx_base[k] = ADDR_W'(ORIGIN) + rx_acc;
            rx_acc     = rx_acc + ADDR_W'(rx_size[k]);
        end
    end

    // transmit regions packed against the window end, channel order kept
    always_comb begin
        tx_acc = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            tx_acc     = tx_acc + ADDR_W'(tx_size[k]);
            tx_base[k] = ADDR_W'(WIN_END) - tx_acc;
        end
    end
endmodule

// File: rtl/fpc_class.sv
module fpc_class
    import fpc_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned ORIGIN = 0,
    parameter int unsigned WORDS  = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_we,
    input  logic                       upd_we,
    input  logic [NCH-1:0]             size_we,
    input  logic [31:0]                wdata,
    input  logic [NCH-1:0]             rx_busy,
    input  logic [NCH-1:0]             tx_busy,
    input  logic [NCH-1:0]             rx_empty,
    input  logic [NCH-1:0]             tx_empty,
    output logic [NCH-1:0][SIZE_W-1:0] pend_rx,
    output logic [NCH-1:0][SIZE_W-1:0] pend_tx,
    output logic [NCH-1:0][SIZE_W-1:0] act_rx,
    output logic [NCH-1:0][SIZE_W-1:0] act_tx,
    output logic [NCH-1:0][ADDR_W-1:0] rx_base,
    output logic [NCH-1:0][ADDR_W-1:0] tx_base,
    output logic                       rx_hold,
    output logic                       tx_hold,
    output logic [31:0]                status
);
    typedef struct packed {
        logic [NCH-1:0][SIZE_W-1:0] pend_rx;
        logic [NCH-1:0][SIZE_W-1:0] pend_tx;
        logic [NCH-1:0][SIZE_W-1:0] act_rx;
        logic [NCH-1:0][SIZE_W-1:0] act_tx;
        logic                       rx_pause;
        logic                       tx_pause;
    } state_t;

    state_t s_d, s_q;

    logic        rx_paused, tx_paused;
    logic        rx_all_empty, tx_all_empty;
    logic        commit_rx, commit_tx, fits;
    logic [31:0] cand_total, act_total;
    logic [NCH-1:0] rx_en, tx_en;
    logic        unused_wdata;

    assign unused_wdata = ^wdata;

    // paused once requested and nothing is in flight
    assign rx_paused = s_q.rx_pause & ~(|rx_busy);
    assign tx_paused = s_q.tx_pause & ~(|tx_busy);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            rx_en[i] = (s_q.act_rx[i] != '0);
            tx_en[i] = (s_q.act_tx[i] != '0);
        end
    end

    assign rx_all_empty = &(rx_empty | ~rx_en);
    assign tx_all_empty = &(tx_empty | ~tx_en);

    assign commit_rx = upd_we & wdata[UPD_RX_BIT] & rx_paused;
    assign commit_tx = upd_we & wdata[UPD_TX_BIT] & tx_paused;

    // totals after a possible commit, and as currently active
    always_comb begin
        cand_total = '0;
        act_total  = '0;
        for (int i = 0; i < NCH; i++) begin
            cand_total = cand_total
                       + 32'(commit_rx ? s_q.pend_rx[i] : s_q.act_rx[i])
                       + 32'(commit_tx ? s_q.pend_tx[i] : s_q.act_tx[i]);
            act_total  = act_total + 32'(s_q.act_rx[i]) + 32'(s_q.act_tx[i]);
        end
    end

    assign fits = (cand_total <= 32'(WORDS));

    always_comb begin
        s_d = s_q;
        if (fits && commit_rx) s_d.act_rx = s_q.pend_rx;
        if (fits && commit_tx) s_d.act_tx = s_q.pend_tx;
        if (ctl_we) begin
            s_d.rx_pause = wdata[ST_RX_PAUSED];
            s_d.tx_pause = wdata[ST_TX_PAUSED];
        end
        for (int i = 0; i < NCH; i++) begin
            if (size_we[i]) begin
                s_d.pend_rx[i] = wdata[SZ_RX_LSB +: SIZE_W];
                s_d.pend_tx[i] = wdata[SZ_TX_LSB +: SIZE_W];
                s_d.rx_pause   = 1'b1;
                s_d.tx_pause   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pend_rx  <= '0;
            s_q.pend_tx  <= '0;
            s_q.act_rx   <= '0;
            s_q.act_tx   <= '0;
            s_q.rx_pause <= 1'b1;
            s_q.tx_pause <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    fpc_layout #(
        .NCH(NCH), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W),
        .ORIGIN(ORIGIN), .WORDS(WORDS)
    ) u_layout (
        .rx_size(s_q.act_rx),
        .tx_size(s_q.act_tx),
        .rx_base(rx_base),
        .tx_base(tx_base)
    );

    assign pend_rx = s_q.pend_rx;
    assign pend_tx = s_q.pend_tx;
    assign act_rx  = s_q.act_rx;
    assign act_tx  = s_q.act_tx;
    assign rx_hold = s_q.rx_pause;
    assign tx_hold = s_q.tx_pause;

    always_comb begin
        status               = '0;
        status[ST_RX_PAUSED] = rx_paused;
        status[ST_RX_EMPTY]  = rx_all_empty;
        status[ST_TX_PAUSED] = tx_paused;
        status[ST_TX_EMPTY]  = tx_all_empty;
    end

    // R6
    rx_commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_rx) |-> $past(upd_we && wdata[UPD_RX_BIT] && rx_paused));
    // R6
    tx_commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_tx) |-> $past(upd_we && wdata[UPD_TX_BIT] && tx_paused));
    // R2
    size_write_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_we != '0) |=> (rx_hold && tx_hold));
    // R10
    rx_unpause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_hold) |-> $past(ctl_we));
    // R10
    tx_unpause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_hold) |-> $past(ctl_we));
    // R7
    window_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_total <= 32'(WORDS));
    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_base[NCH-1]) + 32'(act_rx[NCH-1]) <= 32'(tx_base[0]));
endmodule

// File: rtl/fifo_partition_ctrl.sv
module fifo_partition_ctrl
    import fpc_pkg::*;
#(
    parameter int unsigned NU         = 4,
    parameter int unsigned NS         = 2,
    parameter int unsigned SW         = 8,
    parameter int unsigned UART_WORDS = 512,
    parameter int unsigned SPI_WORDS  = 256,
    parameter int unsigned AW         = $clog2(UART_WORDS + SPI_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic [NU-1:0]    uart_rx_busy,
    input  logic [NU-1:0]    uart_tx_busy,
    input  logic [NU-1:0]    uart_rx_empty,
    input  logic [NU-1:0]    uart_tx_empty,
    input  logic [NS-1:0]    spi_rx_busy,
    input  logic [NS-1:0]    spi_tx_busy,
    input  logic [NS-1:0]    spi_rx_empty,
    input  logic [NS-1:0]    spi_tx_empty,
    output logic             uart_rx_hold,
    output logic             uart_tx_hold,
    output logic             spi_rx_hold,
    output logic             spi_tx_hold,
    output logic [NU*SW-1:0] uart_rx_size,
    output logic [NU*SW-1:0] uart_tx_size,
    output logic [NU*AW-1:0] uart_rx_base,
    output logic [NU*AW-1:0] uart_tx_base,
    output logic [NS*SW-1:0] spi_rx_size,
    output logic [NS*SW-1:0] spi_tx_size,
    output logic [NS*AW-1:0] spi_rx_base,
    output logic [NS*AW-1:0] spi_tx_base
);
    localparam int unsigned SPI_ORIGIN = UART_WORDS;

    logic       wr_uart, wr_spi;
    logic [2:0] wr_off, rd_off;

    assign wr_uart = wr_en & ~wr_addr[3];
    assign wr_spi  = wr_en &  wr_addr[3];
    assign wr_off  = wr_addr[2:0];
    assign rd_off  = rd_addr[2:0];

    logic [NU-1:0] u_size_we;
    logic [NS-1:0] s_size_we;

    for (genvar i = 0; i < NU; i++) begin : g_usel
        assign u_size_we[i] = wr_uart & (wr_off == 3'(OFF_SIZE0 + i));
    end
    for (genvar i = 0; i < NS; i++) begin : g_ssel
        assign s_size_we[i] = wr_spi & (wr_off == 3'(OFF_SIZE0 + i));
    end

    logic [NU-1:0][SW-1:0] u_pend_rx, u_pend_tx, u_act_rx, u_act_tx;
    logic [NU-1:0][AW-1:0] u_rx_base, u_tx_base;
    logic [NS-1:0][SW-1:0] s_pend_rx, s_pend_tx, s_act_rx, s_act_tx;
    logic [NS-1:0][AW-1:0] s_rx_base, s_tx_base;
    logic [31:0]           u_status, s_status;

    fpc_class #(
        .NCH(NU), .SIZE_W(SW), .ADDR_W(AW), .ORIGIN(0), .WORDS(UART_WORDS)
    ) u_uart_cls (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(wr_uart & (wr_off == 3'(OFF_CTL))),
        .upd_we(wr_uart & (wr_off == 3'(OFF_UPD))),
        .size_we(u_size_we), .wdata(wr_data),
        .rx_busy(uart_rx_busy), .tx_busy(uart_tx_busy),
        .rx_empty(uart_rx_empty), .tx_empty(uart_tx_empty),
        .pend_rx(u_pend_rx), .pend_tx(u_pend_tx),
        .act_rx(u_act_rx), .act_tx(u_act_tx),
        .rx_base(u_rx_base), .tx_base(u_tx_base),
        .rx_hold(uart_rx_hold), .tx_hold(uart_tx_hold),
        .status(u_status)
    );

    fpc_class #(
        .NCH(NS), .SIZE_W(SW), .ADDR_W(AW), .ORIGIN(SPI_ORIGIN), .WORDS(SPI_WORDS)
    ) u_spi_cls (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(wr_spi & (wr_off == 3'(OFF_CTL))),
        .upd_we(wr_spi & (wr_off == 3'(OFF_UPD))),
        .size_we(s_size_we), .wdata(wr_data),
        .rx_busy(spi_rx_busy), .tx_busy(spi_tx_busy),
        .rx_empty(spi_rx_empty), .tx_empty(spi_tx_empty),
        .pend_rx(s_pend_rx), .pend_tx(s_pend_tx),
        .act_rx(s_act_rx), .act_tx(s_act_tx),
        .rx_base(s_rx_base), .tx_base(s_tx_base),
        .rx_hold(spi_rx_hold), .tx_hold(spi_tx_hold),
        .status(s_status)
    );

    assign uart_rx_size = u_act_rx;
    assign uart_tx_size = u_act_tx;
    assign uart_rx_base = u_rx_base;
    assign uart_tx_base = u_tx_base;
    assign spi_rx_size  = s_act_rx;
    assign spi_tx_size  = s_act_tx;
    assign spi_rx_base  = s_rx_base;
    assign spi_tx_base  = s_tx_base;

    // read mux: status at offset 0, zero at 1, staged sizes from offset 2
    always_comb begin
        rd_data = '0;
        if (rd_off == 3'(OFF_CTL)) begin
            rd_data = rd_addr[3] ? s_status : u_status;
        end else if (!rd_addr[3]) begin
            for (int i = 0; i < NU; i++) begin
                if (rd_off == 3'(OFF_SIZE0 + i)) begin
                    rd_data[SZ_RX_LSB +: SW] = u_pend_rx[i];
                    rd_data[SZ_TX_LSB +: SW] = u_pend_tx[i];
                end
            end
        end else begin
            for (int i = 0; i < NS; i++) begin
                if (rd_off == 3'(OFF_SIZE0 + i)) begin
                    rd_data[SZ_RX_LSB +: SW] = s_pend_rx[i];
                    rd_data[SZ_TX_LSB +: SW] = s_pend_tx[i];
                end
            end
        end
    end
endmodule

// File: tb/fifo_partition_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_partition_ctrl_tb;
    localparam int NU = 4, NS = 2, SW = 8, AW = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [NU-1:0] u_rxb = '0, u_txb = '0, u_rxe = '1, u_txe = '1;
    logic [NS-1:0] s_rxb = '0, s_txb = '0, s_rxe = '1, s_txe = '1;
    logic u_rxh, u_txh, s_rxh, s_txh;
    logic [NU*SW-1:0] u_rxs, u_txs;
    logic [NU*AW-1:0] u_rxbase, u_txbase;
    logic [NS*SW-1:0] s_rxs, s_txs;
    logic [NS*AW-1:0] s_rxbase, s_txbase;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int erx[4], etx[4];

    always #4 clk = ~clk;

    fifo_partition_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .uart_rx_busy(u_rxb), .uart_tx_busy(u_txb), .uart_rx_empty(u_rxe), .uart_tx_empty(u_txe),
        .spi_rx_busy(s_rxb), .spi_tx_busy(s_txb), .spi_rx_empty(s_rxe), .spi_tx_empty(s_txe),
        .uart_rx_hold(u_rxh), .uart_tx_hold(u_txh), .spi_rx_hold(s_rxh), .spi_tx_hold(s_txh),
        .uart_rx_size(u_rxs), .uart_tx_size(u_txs), .uart_rx_base(u_rxbase), .uart_tx_base(u_txbase),
        .spi_rx_size(s_rxs), .spi_tx_size(s_txs), .spi_rx_base(s_rxbase), .spi_tx_base(s_txbase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // expected UART layout from erx/etx: window 0..511
    task automatic chk_uart_layout(input string tag);
        int acc;
        acc = 0;
        for (int k = 0; k < NU; k++) begin
            chk({tag, " R8 rx base"}, int'(u_rxbase[k*AW +: AW]), acc);
            chk({tag, " R6 rx size"}, int'(u_rxs[k*SW +: SW]), erx[k]);
            acc += erx[k];
        end
        acc = 0;
        for (int k = NU - 1; k >= 0; k--) begin
            acc += etx[k];
            chk({tag, " R8 tx base"}, int'(u_txbase[k*AW +: AW]), 512 - acc);
            chk({tag, " R6 tx size"}, int'(u_txs[k*SW +: SW]), etx[k]);
        end
    endtask

    task automatic stage_uart(input int r[4], input int t[4]);
        for (int k = 0; k < NU; k++)
            wr(4'(2 + k), (32'(t[k]) << 16) | 32'(r[k]));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int r[4], t[4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, d); chk("R1 uart status", int'(d), 32'h606);
        rd(4'h8, d); chk("R1 spi status", int'(d), 32'h606);
        chk("R1 holds", int'({u_rxh, u_txh, s_rxh, s_txh}), 15);
        for (int k = 0; k < NU; k++) begin erx[k] = 0; etx[k] = 0; end
        chk_uart_layout("R1");
        chk("R1 spi rx base1", int'(s_rxbase[AW +: AW]), 512);
        chk("R1 spi tx base0", int'(s_txbase[0 +: AW]), 768);

        // sweep of UART size patterns with commit and empty status
        for (int p = 0; p < 16; p++) begin
            for (int k = 0; k < NU; k++) begin
                r[k] = ((p >> k) & 1) ? ((p * 37 + k * 11) % 50) + 1 : 0;
                t[k] = (((p ^ 5) >> k) & 1) ? ((p * 13 + k * 7) % 40) + 1 : 0;
            end
            wr(4'h0, 32'h0);                  // unpause first
            stage_uart(r, t);
            chk("R2 hold after size write", int'({u_rxh, u_txh}), 3);
            rd(4'(2 + (p % 4)), d);
            chk("R2 readback", int'(d), (t[p % 4] << 16) | r[p % 4]);
            chk_uart_layout("R2 unchanged");
            for (int k = 0; k < NU; k++) begin erx[k] = r[k]; etx[k] = t[k]; end
            wr(4'h1, 32'h3);
            chk_uart_layout("commit");
            chk("R10 hold after commit", int'({u_rxh, u_txh}), 3);
            chk("R9 spi untouched", int'(s_rxs), 0);
            for (int e = 0; e < 16; e++) begin
                int exp_r, exp_t;
                u_rxe = 4'(e); u_txe = ~4'(e);
                exp_r = 1; exp_t = 1;
                for (int k = 0; k < NU; k++) begin
                    if (erx[k] != 0 && !((e >> k) & 1)) exp_r = 0;
                    if (etx[k] != 0 && ((e >> k) & 1)) exp_t = 0;
                end
                rd(4'h0, d);
                chk("R5 rx empty", int'(d[2]), exp_r);
                chk("R5 tx empty", int'(d[10]), exp_t);
            end
        end
        u_rxe = '1; u_txe = '1;

        // R3 / R4 pause control and paused status
        wr(4'h0, 32'h0);
        chk("R3 unpause holds", int'({u_rxh, u_txh}), 0);
        rd(4'h0, d); chk("R4 unpaused status", int'({d[9], d[1]}), 0);
        wr(4'h0, 32'h2);
        chk("R3 rx only hold", int'({u_rxh, u_txh}), 2);
        rd(4'h0, d); chk("R4 rx only paused", int'({d[9], d[1]}), 1);
        wr(4'h0, 32'h202);
        u_rxb = 4'b0100;
        rd(4'h0, d); chk("R4 rx busy blocks paused", int'({d[9], d[1]}), 2);

        // R6 commit ignored while busy, then while unpaused
        r = '{20, 0, 30, 5}; t = '{10, 10, 0, 0};
        stage_uart(r, t);
        wr(4'h1, 32'h1);
        chk_uart_layout("R6 busy ignored");
        u_rxb = '0;
        wr(4'h0, 32'h0);
        wr(4'h1, 32'h3);
        chk_uart_layout("R6 unpaused ignored");
        wr(4'h0, 32'h202);
        wr(4'h1, 32'h3);
        for (int k = 0; k < NU; k++) begin erx[k] = r[k]; etx[k] = t[k]; end
        chk_uart_layout("R6 paused taken");

        // R7 window overflow refused, exact fit accepted
        r = '{200, 200, 0, 0}; t = '{150, 0, 0, 0};
        stage_uart(r, t);
        wr(4'h1, 32'h3);
        chk_uart_layout("R7 overflow refused");
        r = '{200, 200, 0, 0}; t = '{0, 0, 0, 112};
        stage_uart(r, t);
        wr(4'h1, 32'h3);
        for (int k = 0; k < NU; k++) begin erx[k] = r[k]; etx[k] = t[k]; end
        chk_uart_layout("R7 exact fit");

        // SPI class, R9 isolation
        wr(4'h8 | 4'h2, (32'd5 << 16) | 32'd10);
        wr(4'h8 | 4'h3, (32'd6 << 16) | 32'd20);
        wr(4'h8 | 4'h1, 32'h3);
        chk("R8 spi rx base0", int'(s_rxbase[0 +: AW]), 512);
        chk("R8 spi rx base1", int'(s_rxbase[AW +: AW]), 522);
        chk("R8 spi tx base0", int'(s_txbase[0 +: AW]), 757);
        chk("R8 spi tx base1", int'(s_txbase[AW +: AW]), 762);
        wr(4'h8, 32'h0);
        chk("R9 spi holds", int'({s_rxh, s_txh}), 0);
        chk("R9 uart holds", int'({u_rxh, u_txh}), 3);
        chk_uart_layout("R9 uart kept");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule